// File: doc/BRIEF.md
# Packed 16-bit Lane Multiplier

This block multiplies two 64-bit operands as four independent 16-bit lanes and returns one 16-bit slice of each 32-bit lane product. An 8-bit opcode chooses the slice: the low half, the high half of a signed product, the high half of an unsigned product, or a rounded signed slice that adds one half of the result's least significant bit (2^14) before it takes product bits 30 down to 15.

Operations enter with an input valid strobe and leave exactly two clocks later with an output valid strobe. A new operation may enter on every clock; the opcode travels with its data, so consecutive operations may use different modes. An opcode that names none of the four modes still flows through the pipeline and produces all-zero lanes.

Top module: `pmul16x4`

## Requirements
- R1: Opcode 0xD5 returns bits 15:0 of each lane product; the result is the same whether the lanes are read as signed or unsigned.
- R2: Opcode 0xE5 returns bits 31:16 of each signed (two's complement) 16x16 lane product.
- R3: Opcode 0xE4 returns bits 31:16 of each unsigned 16x16 lane product.
- R4: Opcode 0xB7 forms the signed lane product, adds 0x4000 and returns bits 30:15 of the 32-bit sum, wrapping with no saturation, so 0x8000 times 0x8000 gives 0x8000.
- R5: out_valid is high exactly when in_valid was high two clocks earlier; one operation may be accepted on every clock with any mix of opcodes.
- R6: Lane i uses bits [16i+15:16i] of in_a, in_b and out_data for i = 0..3, and no carry or rounding crosses from one lane into another.
- R7: Any other opcode value produces 0x0000 in every lane, with out_valid still following in_valid.
- R8: While rst is high and in the first clocks after it, out_valid is 0 and out_data is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present on the inputs this clock |
| in_op | input | 8 | Opcode selecting the product slice |
| in_a | input | 64 | First operand, four 16-bit lanes |
| in_b | input | 64 | Second operand, four 16-bit lanes |
| out_valid | output | 1 | Result present on out_data |
| out_data | output | 64 | Four 16-bit lane results |

## Verification
On every cycle the assertions check the two-clock valid latency, that a zero lane operand yields a zero lane result in every mode, that the unsigned high half never exceeds its first operand, that the signed high half carries the product's sign, and that the rounded mode wraps the most negative square to 0x8000. Exact lane values for each opcode, lane placement and isolation, unknown opcodes and back-to-back mode changes can only be shown by the bench, whose reference model predicts every output word from the inputs it drove two clocks before.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    // Opcode values that select a product slice
    localparam logic [7:0] OPC_MUL_LO     = 8'hD5;
    localparam logic [7:0] OPC_MUL_HI_S   = 8'hE5;
    localparam logic [7:0] OPC_MUL_HI_U   = 8'hE4;
    localparam logic [7:0] OPC_MUL_HI_RND = 8'hB7;

    typedef enum logic [2:0] {
        XM_NONE   = 3'd0,
        XM_LOW    = 3'd1,
        XM_HIGH_S = 3'd2,
        XM_HIGH_U = 3'd3,
        XM_ROUND  = 3'd4
    } xmode_e;

    typedef struct packed {
        logic   vld;
        xmode_e mode;
    } ctl_t;

    // Only the unsigned high slice treats lane operands as unsigned
    function automatic logic mode_is_unsigned(input xmode_e m);
        return (m == XM_HIGH_U);
    endfunction

endpackage

// File: rtl/pmul_opdec.sv
module pmul_opdec
    import pmul_pkg::*;
(
    input  logic [7:0] op,
    output xmode_e     mode
);

    always_comb begin
        unique case (op)
            OPC_MUL_LO:     mode = XM_LOW;
            OPC_MUL_HI_S:   mode = XM_HIGH_S;
            OPC_MUL_HI_U:   mode = XM_HIGH_U;
            OPC_MUL_HI_RND: mode = XM_ROUND;
            default:        mode = XM_NONE;
        endcase
    end

endmodule

// File: rtl/pmul_lane.sv
module pmul_lane
    import pmul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_s1,
    input  xmode_e       mode_s0,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ld_s2,
    input  xmode_e       mode_s1,
    output logic [W-1:0] res
);

    localparam int PW = 2 * W;
    localparam logic [W-1:0] MIN_PAT = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0]    ax;
    logic signed [W:0]    bx;
    logic signed [PW-1:0] full;
    logic [PW-1:0]        prod_q;
    logic [W-1:0]         rnd_hi;
    logic [W-1:0]         pick;

    // One 17x17 signed multiplier serves both signednesses
    always_comb begin
        if (mode_is_unsigned(mode_s0)) begin
            ax = {1'b0, a};
            bx = {1'b0, b};
        end else begin
            ax = {a[W-1], a};
            bx = {b[W-1], b};
        end
    end

    assign full = PW'(ax) * PW'(bx);

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
        end else if (ld_s1) begin
            prod_q <= full;
        end
    end

    // Adding 2^(W-2) then dropping bits below W-1 equals adding bit W-2
    assign rnd_hi = prod_q[PW-2:W-1] + {{(W-1){1'b0}}, prod_q[W-2]};

    always_comb begin
        unique case (mode_s1)
            XM_LOW:    pick = prod_q[W-1:0];
            XM_HIGH_S: pick = prod_q[PW-1:W];
            XM_HIGH_U: pick = prod_q[PW-1:W];
            XM_ROUND:  pick = rnd_hi;
            default:   pick = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else if (ld_s2) begin
            res <= pick;
        end
    end

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (ld_s1 && ((a == '0) || (b == '0))) |-> ##2 (res == '0)); // R6

    AST_UNSIGNED_BOUND: assert property (@(posedge clk) disable iff (rst)
        (ld_s1 && (mode_s0 == XM_HIGH_U)) |-> ##2 (res <= $past(a, 2))); // R3

    AST_SIGNED_SIGN: assert property (@(posedge clk) disable iff (rst)
        (ld_s1 && (mode_s0 == XM_HIGH_S) && (a != '0) && (b != '0))
        |-> ##2 (res[W-1] == ($past(a[W-1], 2) ^ $past(b[W-1], 2)))); // R2

    AST_ROUND_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ld_s1 && (mode_s0 == XM_ROUND) && (a == MIN_PAT) && (b == MIN_PAT))
        |-> ##2 (res == MIN_PAT)); // R4

endmodule

// File: rtl/pmul16x4.sv
module pmul16x4
    import pmul_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [7:0]              in_op,
    input  logic [LANES*LANE_W-1:0] in_a,
    input  logic [LANES*LANE_W-1:0] in_b,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_data
);

    localparam int DATA_W = LANES * LANE_W;

    xmode_e dec_mode;
    ctl_t   s1_q;
    logic [1:0] warm_q;
    logic [LANE_W-1:0] lane_res [LANES];

    pmul_opdec u_opdec (
        .op   (in_op),
        .mode (dec_mode)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q      <= '{vld: 1'b0, mode: XM_NONE};
            out_valid <= 1'b0;
        end else begin
            s1_q.vld  <= in_valid;
            if (in_valid) begin
                s1_q.mode <= dec_mode;
            end
            out_valid <= s1_q.vld;
        end
    end

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            pmul_lane #(.W(LANE_W)) u_lane (
                .clk     (clk),
                .rst     (rst),
                .ld_s1   (in_valid),
                .mode_s0 (dec_mode),
                .a       (in_a[i*LANE_W +: LANE_W]),
                .b       (in_b[i*LANE_W +: LANE_W]),
                .ld_s2   (s1_q.vld),
                .mode_s1 (s1_q.mode),
                .res     (lane_res[i])
            );
            assign out_data[i*LANE_W +: LANE_W] = lane_res[i];
        end
    endgenerate

    // Cycles since reset, saturating at the pipeline depth
    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && (out_data == {DATA_W{1'b0}}))); // R8

endmodule

// File: tb/pmul16x4_bench.sv
module pmul16x4_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_op = 8'h00;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          v;
        bit          in_rst;
        logic [63:0] d;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    pmul16x4 u_pmul16x4 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [15:0] lane_ref(input logic [7:0] op,
                                             input logic [15:0] a,
                                             input logic [15:0] b);
        longint sa, sb, ua, ub, p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ua = longint'(a);
        ub = longint'(b);
        case (op)
            8'hD5: p = ua * ub;
            8'hE5: p = (sa * sb) >>> 16;
            8'hE4: p = (ua * ub) >> 16;
            8'hB7: p = (sa * sb + 16384) >>> 15;
            default: p = 0;
        endcase
        return p[15:0];
    endfunction

    function automatic string op_tag(input logic [7:0] op);
        case (op)
            8'hD5: return "R1";
            8'hE5: return "R2";
            8'hE4: return "R3";
            8'hB7: return "R4";
            default: return "R7";
        endcase
    endfunction

    // One clock: check the word due now, then drive and model the next
    task automatic step(input bit v, input logic [7:0] op,
                        input logic [63:0] a, input logic [63:0] b,
                        input string tag_over);
        exp_t e;
        exp_t n;
        @(negedge clk);
        if (q.size() == 2) begin
            e = q.pop_front();
            checks++;
            if (out_valid !== e.v) begin
                errors++;
                $display("FAIL R5 (%s): out_valid=%0b expected %0b", e.tag, out_valid, e.v);
            end
            if (e.v || e.in_rst) begin
                checks++;
                if (out_data !== e.d) begin
                    errors++;
                    $display("FAIL %s: out_data=%h expected %h", e.tag, out_data, e.d);
                end
            end
        end
        in_valid = v;
        in_op    = op;
        in_a     = a;
        in_b     = b;
        n.v      = v && !rst;
        n.in_rst = rst;
        n.d      = '0;
        if (!rst) begin
            for (int i = 0; i < 4; i++) begin
                n.d[i*16 +: 16] = lane_ref(op, a[i*16 +: 16], b[i*16 +: 16]);
            end
        end
        n.tag = rst ? "R8" : ((tag_over != "") ? tag_over : op_tag(op));
        q.push_back(n);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, '0, '0, "R5");
    endtask

    initial begin
        logic [7:0] ops [4];
        ops[0] = 8'hD5; ops[1] = 8'hE5; ops[2] = 8'hE4; ops[3] = 8'hB7;

        // R8: reset holds the outputs quiet, even with stimulus applied
        for (int i = 0; i < 4; i++) step(1'b1, 8'hE5, 64'hFFFF_8000_7FFF_1234, 64'h8000_8000_7FFF_4321, "R8");
        @(negedge clk);
        rst = 1'b0;
        q.delete();
        checks++;
        if (out_valid !== 1'b0 || out_data !== 64'h0) begin
            errors++;
            $display("FAIL R8: valid=%0b data=%h expected 0 and %h", out_valid, out_data, 64'h0);
        end
        idle(2);

        // Corner operands in every mode, back to back (R1..R4, R5)
        foreach (ops[k]) begin
            step(1'b1, ops[k], 64'h8000_FFFF_7FFF_8000, 64'h8000_FFFF_7FFF_7FFF, "");
            step(1'b1, ops[k], 64'hFFFF_0001_8000_00FF, 64'h0001_FFFF_FFFF_FF00, "");
        end
        // R4: most negative square wraps in every lane
        step(1'b1, 8'hB7, {4{16'h8000}}, {4{16'h8000}}, "R4");
        // R4: rounding boundary, product 0x4000 rounds to 1, 0x3FFF to 0
        step(1'b1, 8'hB7, 64'h0001_0001_0000_4000, 64'h4000_3FFF_0000_0001, "R4");
        // R1: low half independent of signedness
        step(1'b1, 8'hD5, 64'hFFFF_8000_FFFE_0003, 64'hFFFF_0002_0003_FFFD, "R1");
        // R6: one lane saturated, neighbours zero; no carry crosses lanes
        for (int i = 0; i < 4; i++) begin
            logic [63:0] a1;
            logic [63:0] b1;
            a1 = '0; b1 = '0;
            a1[i*16 +: 16] = 16'hFFFF;
            b1[i*16 +: 16] = 16'hFFFF;
            step(1'b1, ops[i], a1, b1, "R6");
        end
        step(1'b1, 8'hB7, 64'h0000_4000_0000_7FFF, 64'h0000_0001_0000_7FFF, "R6");
        // R7: undefined opcodes give zero lanes but still report valid
        step(1'b1, 8'h00, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
        step(1'b1, 8'hE6, 64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF, "R7");
        step(1'b1, 8'hD4, 64'h0002_0002_0002_0002, 64'h0003_0003_0003_0003, "R7");
        // R5: bubbles between operations
        step(1'b1, 8'hE4, 64'hFFFF_0000_1111_2222, 64'hFFFF_1234_3333_4444, "R5");
        idle(1);
        step(1'b1, 8'hE5, 64'hABCD_0000_1111_2222, 64'h8001_1234_3333_4444, "R5");
        idle(3);

        // Random traffic with mixed modes and gaps
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] op;
            op = ($urandom_range(0, 9) == 0) ? 8'($urandom) : ops[$urandom_range(0, 3)];
            step($urandom_range(0, 4) != 0, op,
                 {$urandom, $urandom}, {$urandom, $urandom}, "");
        end
        idle(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL R5: watchdog expired, actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule